// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a physical address. It reads a two-level translation table held in memory and uses 4 KB pages. A requester presents the address together with two flags: whether the access is a write and whether it comes from user level. The walker then reads the directory word and, when needed, the table word through a simple synchronous memory port. It checks the permission bits in those words and returns either a physical address or a fault.

While walking, the block marks entries as used. It sets the accessed bit in each entry it relies on, and it sets the dirty bit in the final table word on a write. Each update is a read-modify-write of the same word, and it is issued only when the word would actually change. A directory entry with its size bit set maps a 4 MB region, and the walk stops at that level. On any fault the linear address is held in a fault-address register until the next fault.

Top module: `xlat_walker`

## Requirements
- R1: The directory word is read at byte address {root_base, va[31:22], 2'b00}. The table word is read at {dir[31:12], va[21:12], 2'b00}. A 4 KB mapping yields paddr = {tbl[31:12], va[11:0]}.
- R2: When bit 7 of a present directory word is 1, no table word is read and paddr = {dir[31:22], va[21:0]}.
- R3: When bit 0 (present) of the directory word or of the table word is 0, the response carries fault = 1 and that word is not written.
- R4: On a faulting response fault_addr shows the request's linear address. fault_addr changes at no other time and reads 0 after reset.
- R5: A user write faults unless bit 1 is 1 in every word used (directory only for a 4 MB mapping, both words otherwise). Supervisor writes ignore bit 1.
- R6: A user access faults unless bit 2 is 1 in every word used. Supervisor accesses ignore bit 2.
- R7: Bit 5 (accessed) is set in a present directory word once the walk continues past it or maps a 4 MB region with it, and in the table word of every successful 4 KB translation.
- R8: Bit 6 (dirty) is set in the table word on a successful write. It is never set in a directory word by the walker.
- R9: A write-back goes to the address read two cycles earlier, clears no bit, and is issued only when the new word differs from the word read.
- R10: req_ready is 1 only when the walker is idle. done is a single-cycle pulse that comes with valid fault and paddr. Memory read data is expected one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 20 | Frame number of the directory |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user level |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_wdata | output | 32 | Updated entry word |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| done | output | 1 | Response pulse |
| fault | output | 1 | Response is a fault |
| paddr | output | 32 | Translated physical address |
| fault_addr | output | 32 | Last faulting linear address |

## Verification
Some properties hold on every cycle, and the bound checker watches these at the ports. Every write-back must reuse the address read two cycles before, must keep all bits it read, must set the accessed bit and must differ from the read word. The done pulse lasts one cycle, memory traffic appears only while the walker is busy, and fault_addr moves only with a faulting response. Other behaviour can only be shown by the bench's scenarios. These include the permission combinations across both levels, the 4 MB short walk, and the exact physical addresses. They also include which words end up accessed or dirty in memory and how many reads and writes each request costs. The bench computes these from its own copy of the tables.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int LG_W    = VA_W - OFF_W - IDX_W;

    localparam int B_P  = 0;
    localparam int B_RW = 1;
    localparam int B_US = 2;
    localparam int B_A  = 5;
    localparam int B_D  = 6;
    localparam int B_PS = 7;

    typedef enum logic [3:0] {
        W_IDLE,
        W_RD_DIR,
        W_CHK_DIR,
        W_WB_DIR,
        W_RD_TBL,
        W_CHK_TBL,
        W_WB_TBL,
        W_RESP
    } wstate_e;

    typedef struct packed {
        wstate_e           st;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic              usr;
        logic [VA_W-1:0]   dir_e;
        logic [VA_W-1:0]   ent_addr;
        logic [VA_W-1:0]   wb_data;
        logic [VA_W-1:0]   pa;
        logic              flt;
        logic [VA_W-1:0]   flt_addr;
    } walk_s;

endpackage

// File: rtl/xlat_perm.sv
module xlat_perm (
    input  logic up_rw,
    input  logic up_us,
    input  logic lo_rw,
    input  logic lo_us,
    input  logic use_lower,
    input  logic user,
    input  logic write,
    output logic deny
);
    logic eff_rw;
    logic eff_us;

    always_comb begin
        eff_rw = up_rw & (lo_rw | ~use_lower);
        eff_us = up_us & (lo_us | ~use_lower);
        deny   = user & (~eff_us | (write & ~eff_rw));
    end
endmodule

// File: rtl/xlat_entry_upd.sv
module xlat_entry_upd
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0] entry,
    input  logic            is_leaf_tbl,
    input  logic            write,
    output logic [VA_W-1:0] new_entry,
    output logic            changed
);
    always_comb begin
        new_entry      = entry;
        new_entry[B_A] = 1'b1;
        if (is_leaf_tbl && write) begin
            new_entry[B_D] = 1'b1;
        end
        changed = (new_entry != entry);
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FRAME_W-1:0]  root_base,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic                req_write,
    input  logic                req_user,
    output logic                mem_req,
    output logic                mem_we,
    output logic [VA_W-1:0]     mem_addr,
    output logic [VA_W-1:0]     mem_wdata,
    input  logic [VA_W-1:0]     mem_rdata,
    output logic                done,
    output logic                fault,
    output logic [VA_W-1:0]     paddr,
    output logic [VA_W-1:0]     fault_addr
);
    walk_s q, d;

    logic            chk_tbl;
    logic [VA_W-1:0] up_word;
    logic            deny;
    logic [VA_W-1:0] upd_word;
    logic            upd_chg;
    logic [VA_W-1:0] tbl_addr_q;

    assign chk_tbl = (q.st == W_CHK_TBL);
    assign up_word = chk_tbl ? q.dir_e : mem_rdata;

    xlat_perm u_perm (
        .up_rw     (up_word[B_RW]),
        .up_us     (up_word[B_US]),
        .lo_rw     (mem_rdata[B_RW]),
        .lo_us     (mem_rdata[B_US]),
        .use_lower (chk_tbl),
        .user      (q.usr),
        .write     (q.wr),
        .deny      (deny)
    );

    xlat_entry_upd u_upd (
        .entry       (mem_rdata),
        .is_leaf_tbl (chk_tbl),
        .write       (q.wr),
        .new_entry   (upd_word),
        .changed     (upd_chg)
    );

    assign tbl_addr_q = {q.dir_e[VA_W-1:OFF_W], q.va[OFF_W +: IDX_W], 2'b00};

    always_comb begin
        d = q;
        case (q.st)
            W_IDLE: begin
                if (req_valid) begin
                    d.va       = req_vaddr;
                    d.wr       = req_write;
                    d.usr      = req_user;
                    d.flt      = 1'b0;
                    d.ent_addr = {root_base, req_vaddr[VA_W-1 -: IDX_W], 2'b00};
                    d.st       = W_RD_DIR;
                end
            end
            W_RD_DIR: d.st = W_CHK_DIR;
            W_CHK_DIR: begin
                d.dir_e   = mem_rdata;
                d.wb_data = upd_word;
                if (!mem_rdata[B_P]) begin
                    d.flt      = 1'b1;
                    d.flt_addr = q.va;
                    d.st       = W_RESP;
                end else if (mem_rdata[B_PS]) begin
                    if (deny) begin
                        d.flt      = 1'b1;
                        d.flt_addr = q.va;
                        d.st       = W_RESP;
                    end else begin
                        d.pa = {mem_rdata[VA_W-1 -: LG_W], q.va[VA_W-LG_W-1:0]};
                        d.st = upd_chg ? W_WB_DIR : W_RESP;
                    end
                end else if (upd_chg) begin
                    d.st = W_WB_DIR;
                end else begin
                    d.ent_addr = {mem_rdata[VA_W-1:OFF_W], q.va[OFF_W +: IDX_W], 2'b00};
                    d.st       = W_RD_TBL;
                end
            end
            W_WB_DIR: begin
                if (q.dir_e[B_PS]) begin
                    d.st = W_RESP;
                end else begin
                    d.ent_addr = tbl_addr_q;
                    d.st       = W_RD_TBL;
                end
            end
            W_RD_TBL: d.st = W_CHK_TBL;
            W_CHK_TBL: begin
                d.wb_data = upd_word;
                if (!mem_rdata[B_P] || deny) begin
                    d.flt      = 1'b1;
                    d.flt_addr = q.va;
                    d.st       = W_RESP;
                end else begin
                    d.pa = {mem_rdata[VA_W-1:OFF_W], q.va[OFF_W-1:0]};
                    d.st = upd_chg ? W_WB_TBL : W_RESP;
                end
            end
            W_WB_TBL: d.st = W_RESP;
            W_RESP:   d.st = W_IDLE;
            default:  d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready  = (q.st == W_IDLE);
        mem_we     = (q.st == W_WB_DIR) || (q.st == W_WB_TBL);
        mem_req    = mem_we || (q.st == W_RD_DIR) || (q.st == W_RD_TBL);
        mem_addr   = q.ent_addr;
        mem_wdata  = q.wb_data;
        done       = (q.st == W_RESP);
        fault      = q.flt;
        paddr      = q.pa;
        fault_addr = q.flt_addr;
    end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [31:0] mem_rdata,
    input logic        done,
    input logic        fault,
    input logic [31:0] fault_addr
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_MEM_BUSY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R10
    AST_WB_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(mem_req && !mem_we, 2) && mem_addr == $past(mem_addr, 2))); // R9
    AST_WB_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (($past(mem_rdata) & ~mem_wdata) == 32'h0)); // R9
    AST_WB_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata != $past(mem_rdata))); // R9
    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0])); // R7
    AST_FADDR_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> (done && fault)); // R4
endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_base = 20'h00001;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        done, fault;
    logic [31:0] paddr, fault_addr;

    always #2 clk = ~clk;

    xlat_walker u0 (.*);

    logic [31:0] mem [0:4095];
    always @(posedge clk) begin
        if (mem_req && mem_we)  mem[mem_addr[13:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[13:2]];
    end

    typedef struct {
        bit          flt;
        logic [31:0] pa;
        logic [31:0] fa;
        int          nw;
        int          nr;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    int n_chk = 0, n_bad = 0;
    logic [31:0] last_fa = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int wr_seen = 0, rd_seen = 0;
    always @(negedge clk) begin
        if (rst_n && mem_req &&  mem_we) wr_seen++;
        if (rst_n && mem_req && !mem_we) rd_seen++;
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(fault == e.flt, {e.tag, " fault"}, 32'(fault), 32'(e.flt));
                if (!e.flt) check(paddr == e.pa, {e.tag, " paddr"}, paddr, e.pa);
                check(fault_addr == e.fa, {e.tag, " R4 fault_addr"}, fault_addr, e.fa);
                check(wr_seen == e.nw, {e.tag, " R9 writes"}, 32'(wr_seen), 32'(e.nw));
                check(rd_seen == e.nr, {e.tag, " R2 reads"}, 32'(rd_seen), 32'(e.nr));
            end
            wr_seen = 0;
            rd_seen = 0;
        end
    end

    task automatic walk(input logic [31:0] va, input bit w, input bit u, input string tag);
        exp_t e;
        logic [31:0] pde, pte, npde, npte, pa_a, pte_a;
        int pi, ti;
        bit reach_tbl, deny;
        pa_a = {root_base, va[31:22], 2'b00};
        pi = int'(pa_a[13:2]);
        pde = mem[pi];
        npde = pde; npte = '0; ti = 0; reach_tbl = 0;
        e.flt = 0; e.pa = '0; e.nw = 0; e.nr = 1; e.tag = tag;
        if (!pde[0]) e.flt = 1;
        else if (pde[7]) begin
            deny = u && (!pde[2] || (w && !pde[1]));
            if (deny) e.flt = 1;
            else begin
                npde = pde | 32'h20;
                e.nw = (npde != pde) ? 1 : 0;
                e.pa = {pde[31:22], va[21:0]};
            end
        end else begin
            npde = pde | 32'h20;
            e.nw = (npde != pde) ? 1 : 0;
            e.nr = 2;
            pte_a = {pde[31:12], va[21:12], 2'b00};
            ti = int'(pte_a[13:2]);
            pte = mem[ti];
            npte = pte;
            reach_tbl = 1;
            deny = u && (!(pde[2] && pte[2]) || (w && !(pde[1] && pte[1])));
            if (!pte[0] || deny) e.flt = 1;
            else begin
                npte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
                if (npte != pte) e.nw++;
                e.pa = {pte[31:12], va[11:0]};
            end
        end
        if (e.flt) last_fa = va;
        e.fa = last_fa;
        sbq.push_back(e);
        @(negedge clk);
        check(req_ready == 1'b1, {tag, " R10 ready idle"}, 32'(req_ready), 32'd1);
        req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        check(mem[pi] == npde, {tag, " R7 dir word"}, mem[pi], npde);
        if (reach_tbl) check(mem[ti] == npte, {tag, " R8 tbl word"}, mem[ti], npte);
    endtask

    function automatic logic [31:0] va_of(input int dr, input int tb, input int off);
        return {dr[9:0], tb[9:0], off[11:0]};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        mem[12'h400] = 32'h0000_2007;
        mem[12'h401] = 32'h0000_0000;
        mem[12'h402] = 32'h00C0_0087;
        mem[12'h403] = 32'h0000_3005;
        mem[12'h404] = 32'h0000_3003;
        mem[12'h405] = 32'h0100_0085;
        mem[12'h800] = 32'h0005_5007;
        mem[12'h801] = 32'h0006_6005;
        mem[12'h802] = 32'h0007_7003;
        mem[12'h803] = 32'h0000_0000;
        mem[12'h804] = 32'h0008_8067;
        mem[12'hC00] = 32'h0009_9007;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && done == 1'b0 && mem_req == 1'b0, "R10 reset idle",
              {29'd0, req_ready, done, mem_req}, 32'h4);
        check(fault_addr == 32'h0, "R4 reset fault_addr", fault_addr, 32'h0);

        walk(va_of(0, 0, 12'h123), 0, 1, "R1 user read 4K");
        walk(va_of(0, 0, 12'hABC), 1, 1, "R8 user write sets dirty");
        walk(va_of(0, 0, 12'h004), 1, 1, "R9 no change no write");
        walk(va_of(1, 0, 12'h010), 0, 0, "R3 dir not present");
        walk(va_of(0, 3, 12'h020), 0, 0, "R3 tbl not present");
        walk(va_of(2, 5, 12'h345), 0, 1, "R2 large read");
        walk(va_of(2, 7, 12'hFFF), 1, 1, "R8 large write no dirty");
        walk(va_of(5, 1, 12'h111), 1, 1, "R5 large ro user write");
        walk(va_of(5, 1, 12'h111), 1, 0, "R5 large ro sup write");
        walk(va_of(3, 0, 12'h200), 1, 1, "R5 dir ro user write");
        walk(va_of(3, 0, 12'h200), 1, 0, "R5 dir ro sup write");
        walk(va_of(0, 1, 12'h300), 1, 1, "R5 tbl ro user write");
        walk(va_of(0, 1, 12'h300), 1, 0, "R5 tbl ro sup write");
        walk(va_of(4, 0, 12'h400), 0, 1, "R6 dir sup-only user");
        walk(va_of(0, 2, 12'h500), 0, 1, "R6 tbl sup-only user");
        walk(va_of(0, 2, 12'h500), 0, 0, "R6 tbl sup-only sup");
        walk(va_of(0, 4, 12'h600), 1, 1, "R9 A D already set");
        walk(va_of(0, 1, 12'h700), 0, 1, "R4 fault_addr held");
        walk(va_of(1023, 0, 12'h0), 0, 1, "R3 last dir not present");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule